// File: doc/BRIEF.md
# Activity LED Pulse Shaper

This block turns short activity indications from one network port into drive levels for three status lights: transmit, receive and collision. A raw activity pulse may last a single clock, far too short to be seen. The block stretches or blinks it so that a person can notice it. All three lights follow the same rules and the same mode inputs, but each has its own shaping state.

Two plain control bits choose one of four modes:
- **Pass-through:** the light copies the activity input.
- **Hold:** each activity keeps the light on for at least a short interval, and new activity restarts that interval.
- **Short blink:** each activity starts one on/off cycle, with the short interval in each phase.
- **Long blink:** the same as short blink, but with the long interval in each phase.

Intervals are counted in ticks of an internal slow time base. The parameter `CLKS_PER_TICK` gives the number of system clocks per tick. The defaults give a 1 ms tick from a 50 MHz clock, with 42 ticks for the short interval and 500 ticks for the long one. A bench can use small values to run fast.

Top module: `act_led_shaper`

## Requirements
- R1: While `rst_n` is low, all three light outputs are 0. The tick counter is cleared, and the remembered mode is pass-through (`stretch_en_i`=0, `blink_en_i`=0).
- R2: A tick occurs in every `CLKS_PER_TICK`-th clock cycle. The first tick is in cycle `CLKS_PER_TICK` after reset release, counting the first cycle with reset released as cycle 1. All interval timing counts these ticks.
- R3: Pass-through mode (`stretch_en_i`=0, `blink_en_i`=0): each light output equals its activity input of the previous cycle.
- R4: Hold mode (`stretch_en_i`=1, `blink_en_i`=0): activity in cycle t lights the output from cycle t+1. The output goes dark in the cycle after the `SHORT_TICKS`-th tick that follows the last activity.
- R5: In hold mode, activity while the light is on reloads the hold count to `SHORT_TICKS`.
- R6: Short blink mode (`stretch_en_i`=0, `blink_en_i`=1): activity on an idle channel lights the output from the next cycle.
  - The output stays on until the `SHORT_TICKS`-th tick.
  - It then stays dark until the `SHORT_TICKS`-th tick after that.
  - The channel is then idle again.
- R7: Long blink mode (both enables 1): the output behaves as in R6, but uses `LONG_TICKS` for both the on phase and the off phase.
- R8: In either blink mode, activity during the on phase is ignored. It does not lengthen the blink and does not cause another one.
- R9: In either blink mode, activity during the off phase is remembered. When the off phase ends, a new on phase starts at once, with no idle gap.
- R10: In any cycle where the mode inputs differ from the previous cycle and the new mode is not pass-through:
  - every channel returns to idle,
  - any remembered activity is dropped,
  - activity in that cycle is ignored,
  - every output is 0 in the next cycle.
- R11: The transmit, receive and collision channels obey R3 to R10 independently, each driven only by its own activity input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stretch_en_i | input | 1 | Hold enable; selects a mode together with the blink enable |
| blink_en_i | input | 1 | Blink enable; selects a mode together with the hold enable |
| act_tx_i | input | 1 | Transmit activity, sampled each clock |
| act_rx_i | input | 1 | Receive activity, sampled each clock |
| act_col_i | input | 1 | Collision activity, sampled each clock |
| led_tx_o | output | 1 | Shaped transmit light drive |
| led_rx_o | output | 1 | Shaped receive light drive |
| led_col_o | output | 1 | Shaped collision light drive |

## Verification
Each mode is tried with the following patterns:
- Single isolated pulses show that the on and off lengths are right. They are placed at several offsets from the tick so that off-by-one tick counting shows up.
- Pulse trains during hold separate a restarting timer from one that expires early.
- Pulses placed in the on phase and in the off phase of a blink separate absorbed activity from remembered activity.

Mode changes are made in the middle of an interval to prove the return to idle. Long runs of seeded random activity, with a different density on each channel, then catch any coupling between channels and any state left over between patterns.

// File: rtl/act_led_pkg.sv
package act_led_pkg;

  // Mode code is {stretch_en, blink_en}
  localparam logic [1:0] MODE_PASS  = 2'b00;
  localparam logic [1:0] MODE_BLINK = 2'b01;
  localparam logic [1:0] MODE_HOLD  = 2'b10;
  localparam logic [1:0] MODE_SLOW  = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_e;

endpackage

// File: rtl/act_led_tick.sv
module act_led_tick #(
  parameter int CLKS_PER_TICK = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/act_led_mode.sv
module act_led_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stretch_en_i,
  input  logic       blink_en_i,
  output logic [1:0] mode_o,
  output logic       restart_o
);
  import act_led_pkg::*;

  logic [1:0] mode_q;

  assign mode_o    = {stretch_en_i, blink_en_i};
  assign restart_o = (mode_o != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PASS;
    end else begin
      mode_q <= mode_o;
    end
  end
endmodule

// File: rtl/act_led_chan.sv
module act_led_chan #(
  parameter int SHORT_TICKS = 42,
  parameter int LONG_TICKS  = 500,
  parameter int TW          = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       restart_i,
  input  logic       act_i,
  output logic       led_o
);
  import act_led_pkg::*;

  phase_e        ph_q, ph_n;
  logic [TW-1:0] tm_q, tm_n;
  logic          pend_q, pend_n;
  logic          led_q, led_n;
  logic [TW-1:0] len;
  logic          last;
  logic          hold_mode;

  assign hold_mode = (mode_i == MODE_HOLD);
  assign len       = (mode_i == MODE_SLOW) ? TW'(LONG_TICKS) : TW'(SHORT_TICKS);
  assign last      = (tm_q == TW'(1));

  always_comb begin
    ph_n   = ph_q;
    tm_n   = tm_q;
    pend_n = pend_q;
    led_n  = 1'b0;
    if (mode_i == MODE_PASS) begin
      ph_n   = PH_IDLE;
      tm_n   = '0;
      pend_n = 1'b0;
      led_n  = act_i;
    end else if (restart_i) begin
      ph_n   = PH_IDLE;
      tm_n   = '0;
      pend_n = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (act_i) begin
            ph_n = PH_ON;
            tm_n = len;
          end
        end
        PH_ON: begin
          if (hold_mode && act_i) begin
            tm_n = len;
          end else if (tick_i) begin
            if (!last) begin
              tm_n = tm_q - 1'b1;
            end else if (hold_mode) begin
              ph_n = PH_IDLE;
              tm_n = '0;
            end else begin
              ph_n = PH_OFF;
              tm_n = len;
            end
          end
        end
        PH_OFF: begin
          if (tick_i && last) begin
            pend_n = 1'b0;
            if (pend_q || act_i) begin
              ph_n = PH_ON;
              tm_n = len;
            end else begin
              ph_n = PH_IDLE;
              tm_n = '0;
            end
          end else begin
            if (tick_i) begin
              tm_n = tm_q - 1'b1;
            end
            if (act_i) begin
              pend_n = 1'b1;
            end
          end
        end
        default: begin
          ph_n   = PH_IDLE;
          tm_n   = '0;
          pend_n = 1'b0;
        end
      endcase
      led_n = (ph_n == PH_ON);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      tm_q   <= '0;
      pend_q <= 1'b0;
      led_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      tm_q   <= tm_n;
      pend_q <= pend_n;
      led_q  <= led_n;
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/act_led_shaper.sv
module act_led_shaper #(
  parameter int CLKS_PER_TICK = 50000,
  parameter int SHORT_TICKS   = 42,
  parameter int LONG_TICKS    = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stretch_en_i,
  input  logic blink_en_i,
  input  logic act_tx_i,
  input  logic act_rx_i,
  input  logic act_col_i,
  output logic led_tx_o,
  output logic led_rx_o,
  output logic led_col_o
);
  localparam int NCH  = 3;
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int TW   = $clog2(MAXT + 1);

  logic           tick;
  logic [1:0]     mode;
  logic           restart;
  logic [NCH-1:0] act_vec;
  logic [NCH-1:0] led_vec;

  assign act_vec = {act_col_i, act_rx_i, act_tx_i};

  act_led_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  act_led_mode u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .stretch_en_i (stretch_en_i),
    .blink_en_i   (blink_en_i),
    .mode_o       (mode),
    .restart_o    (restart)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    act_led_chan #(
      .SHORT_TICKS (SHORT_TICKS),
      .LONG_TICKS  (LONG_TICKS),
      .TW          (TW)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .mode_i    (mode),
      .restart_i (restart),
      .act_i     (act_vec[c]),
      .led_o     (led_vec[c])
    );
  end

  assign led_tx_o  = led_vec[0];
  assign led_rx_o  = led_vec[1];
  assign led_col_o = led_vec[2];
endmodule

// File: rtl/act_led_shaper_chk.sv
module act_led_shaper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stretch_en_i,
  input logic       blink_en_i,
  input logic [2:0] act_i,
  input logic [2:0] led_i,
  input logic       tick_i
);
  logic [1:0] mode;
  logic [1:0] mprev_q;
  logic       up_q;
  logic       steady;

  assign mode   = {stretch_en_i, blink_en_i};
  assign steady = up_q && (mode == mprev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mprev_q <= 2'b00;
      up_q    <= 1'b0;
    end else begin
      mprev_q <= mode;
      up_q    <= 1'b1;
    end
  end

  // R1: outputs dark when reset is released
  assert_reset_dark_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (led_i == 3'b000));

  // R3, R11: pass-through copies each input one cycle later
  assert_pass_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && mode == 2'b00) |=> (led_i == $past(act_i)));

  // R4: activity in steady hold mode lights that channel next cycle
  assert_hold_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && mode == 2'b10 && act_i != 3'b000)
      |=> ((led_i & $past(act_i)) == $past(act_i)));

  // R6: in a steady shaping mode a light only goes dark after a tick
  assert_fall_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && mode != 2'b00)
      |=> (((~led_i & $past(led_i)) == 3'b000) || $past(tick_i)));

  // R9: in blink modes a light only comes on after activity or at a tick
  assert_blink_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && blink_en_i)
      |=> ((led_i & ~$past(led_i) & ~$past(act_i) & {3{~$past(tick_i)}}) == 3'b000));

  // R10: a change into a shaping mode darkens all lights
  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && mode != mprev_q && mode != 2'b00) |=> (led_i == 3'b000));
endmodule

bind act_led_shaper act_led_shaper_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stretch_en_i (stretch_en_i),
  .blink_en_i   (blink_en_i),
  .act_i        (act_vec),
  .led_i        (led_vec),
  .tick_i       (tick)
);

// File: tb/act_led_shaper_bench.sv
module act_led_shaper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPT        = 3;
  localparam int SHORT      = 4;
  localparam int LONG       = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stretch_en = 1'b0;
  logic blink_en = 1'b0;
  logic [2:0] act = 3'b000;
  logic led_tx, led_rx, led_col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference state
  int m_pc;
  logic [1:0] m_mprev;
  int m_ph [3];
  int m_tm [3];
  bit m_pd [3];
  logic [2:0] m_led;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_led_shaper #(
    .CLKS_PER_TICK (CPT),
    .SHORT_TICKS   (SHORT),
    .LONG_TICKS    (LONG)
  ) u_act_led_shaper (
    .clk          (clk),
    .rst_n        (rst_n),
    .stretch_en_i (stretch_en),
    .blink_en_i   (blink_en),
    .act_tx_i     (act[0]),
    .act_rx_i     (act[1]),
    .act_col_i    (act[2]),
    .led_tx_o     (led_tx),
    .led_rx_o     (led_rx),
    .led_col_o    (led_col)
  );

  task automatic model_reset();
    m_pc = 0;
    m_mprev = 2'b00;
    m_led = 3'b000;
    for (int c = 0; c < 3; c++) begin
      m_ph[c] = 0; m_tm[c] = 0; m_pd[c] = 1'b0;
    end
  endtask

  // Model of one clock edge, from R2..R10 (0 idle, 1 on, 2 off)
  task automatic model_step(input logic s, input logic b, input logic [2:0] a);
    bit tick, chg;
    int len;
    tick = (m_pc == CPT - 1);
    m_pc = tick ? 0 : m_pc + 1;
    chg = ({s, b} != m_mprev);
    m_mprev = {s, b};
    len = (s && b) ? LONG : SHORT;
    for (int c = 0; c < 3; c++) begin
      if (!s && !b) begin
        m_ph[c] = 0; m_tm[c] = 0; m_pd[c] = 1'b0;
        m_led[c] = a[c];
      end else if (chg) begin
        m_ph[c] = 0; m_tm[c] = 0; m_pd[c] = 1'b0;
        m_led[c] = 1'b0;
      end else begin
        if (m_ph[c] == 0) begin
          if (a[c]) begin m_ph[c] = 1; m_tm[c] = len; end
        end else if (m_ph[c] == 1) begin
          if (s && !b && a[c]) m_tm[c] = len;
          else if (tick) begin
            if (m_tm[c] != 1) m_tm[c] = m_tm[c] - 1;
            else if (s && !b) begin m_ph[c] = 0; m_tm[c] = 0; end
            else begin m_ph[c] = 2; m_tm[c] = len; end
          end
        end else begin
          if (tick && m_tm[c] == 1) begin
            if (m_pd[c] || a[c]) begin m_ph[c] = 1; m_tm[c] = len; end
            else begin m_ph[c] = 0; m_tm[c] = 0; end
            m_pd[c] = 1'b0;
          end else begin
            if (tick) m_tm[c] = m_tm[c] - 1;
            if (a[c]) m_pd[c] = 1'b1;
          end
        end
        m_led[c] = (m_ph[c] == 1);
      end
    end
  endtask

  task automatic compare();
    logic [2:0] got;
    got = {led_col, led_rx, led_tx};
    for (int c = 0; c < 3; c++) begin
      checks++;
      if (got[c] !== m_led[c]) begin
        errors++;
        $display("FAIL %s channel %0d: led=%b expected=%b at %0t", tag, c, got[c], m_led[c], $time);
      end
    end
  endtask

  task automatic cyc(input logic s, input logic b, input logic [2:0] a);
    @(negedge clk);
    compare();
    stretch_en = s;
    blink_en = b;
    act = a;
    model_step(s, b, a);
  endtask

  task automatic idle(input logic s, input logic b, input int n);
    for (int i = 0; i < n; i++) cyc(s, b, 3'b000);
  endtask

  function automatic logic [2:0] rnd_act(input int pct0, input int pct1, input int pct2);
    logic [2:0] r;
    r[0] = ($urandom % 100) < pct0;
    r[1] = ($urandom % 100) < pct1;
    r[2] = ($urandom % 100) < pct2;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    model_reset();
    // R1: dark during reset
    tag = "R1 reset dark";
    act = 3'b111;
    stretch_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    act = 3'b000;
    stretch_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_step(1'b0, 1'b0, 3'b000);

    // R3: pass-through with random activity
    tag = "R3 pass-through";
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0, rnd_act(50, 30, 70));

    // R4: single hold pulses at each tick offset (also R2 tick spacing)
    tag = "R4 hold single pulse";
    idle(1'b1, 1'b0, 2);
    for (int k = 0; k < CPT; k++) begin
      cyc(1'b1, 1'b0, 3'b111);
      idle(1'b1, 1'b0, SHORT * CPT + 3 + k);
    end
    tag = "R2 tick spacing";
    cyc(1'b1, 1'b0, 3'b001);
    idle(1'b1, 1'b0, 1);
    cyc(1'b1, 1'b0, 3'b010);
    idle(1'b1, 1'b0, SHORT * CPT + 5);

    // R5: retriggered hold
    tag = "R5 hold retrigger";
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 3'b101);
      idle(1'b1, 1'b0, CPT * 2);
    end
    idle(1'b1, 1'b0, SHORT * CPT + 4);

    // R6: short blink single pulse
    tag = "R6 short blink";
    idle(1'b0, 1'b1, 2);
    cyc(1'b0, 1'b1, 3'b111);
    idle(1'b0, 1'b1, 2 * SHORT * CPT + 6);

    // R7: long blink single pulse
    tag = "R7 long blink";
    idle(1'b1, 1'b1, 2);
    cyc(1'b1, 1'b1, 3'b010);
    idle(1'b1, 1'b1, 2 * LONG * CPT + 6);

    // R8: activity during on phase absorbed
    tag = "R8 on-phase absorb";
    idle(1'b0, 1'b1, 2);
    cyc(1'b0, 1'b1, 3'b111);
    for (int i = 0; i < 3; i++) begin
      idle(1'b0, 1'b1, 1);
      cyc(1'b0, 1'b1, 3'b111);
    end
    idle(1'b0, 1'b1, 2 * SHORT * CPT + 6);

    // R9: activity during off phase remembered
    tag = "R9 off-phase latch";
    cyc(1'b0, 1'b1, 3'b011);
    idle(1'b0, 1'b1, SHORT * CPT + 2);
    cyc(1'b0, 1'b1, 3'b001);
    idle(1'b0, 1'b1, 3 * SHORT * CPT + 6);
    tag = "R9 off-phase latch long";
    idle(1'b1, 1'b1, 1);
    cyc(1'b1, 1'b1, 3'b100);
    idle(1'b1, 1'b1, LONG * CPT + 4);
    cyc(1'b1, 1'b1, 3'b100);
    idle(1'b1, 1'b1, 3 * LONG * CPT + 6);

    // R10: mode change mid-interval
    tag = "R10 mode change";
    cyc(1'b1, 1'b0, 3'b111);
    idle(1'b1, 1'b0, 3);
    cyc(1'b0, 1'b1, 3'b111);
    idle(1'b0, 1'b1, 4);
    cyc(1'b1, 1'b1, 3'b111);
    idle(1'b1, 1'b1, 4);
    cyc(1'b0, 1'b0, 3'b010);
    cyc(1'b1, 1'b0, 3'b111);
    idle(1'b1, 1'b0, SHORT * CPT + 4);

    // R11: random independent channels, per mode and with mode hopping
    tag = "R11 random per mode";
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 300; i++) cyc(m[1], m[0], rnd_act(5, 15, 40));
    end
    tag = "R11 random mode hopping";
    for (int i = 0; i < 800; i++) begin
      int m;
      m = (($urandom % 100) < 3) ? int'($urandom % 4) : int'({stretch_en, blink_en});
      cyc(m[1], m[0], rnd_act(8, 20, 3));
    end
    idle(1'b1, 1'b1, 2 * LONG * CPT + 6);

    @(negedge clk);
    compare();
    finish_run();
  end
endmodule